// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small fully associative store for lines that a direct-mapped first-level cache has thrown out. It sits beside that cache, on the path to the next memory level. Each time the cache replaces a line during a normal fill, it passes the old line in through the eviction port. Any entry can take any block, so two blocks that share a direct-mapped index can both stay on chip. The buffer does not lengthen the cache's own hit time.

When the direct-mapped cache misses, it sends the full block address on the lookup port. It also sends the line it would displace, if it holds a valid one. All entries are compared in parallel, and the answer arrives on the following cycle. On a hit the buffer returns the block and stores the displaced line in the same entry, so the two lines swap places. On a miss the buffer issues a memory request for the block in the same cycle as the miss response. An empty entry is filled first. Once the buffer is full, a round-robin replacement pointer picks the entry to overwrite.

Top module: `victim_buf`

## Requirements
- R1: After reset every entry is empty and `resp_valid_o` and `mem_req_valid_o` are low. A lookup issued before any eviction answers as a miss.
- R2: A line entered through the eviction port is found by a later lookup of the same block address, which returns hit with the stored data.
- R3: A lookup sampled at one rising edge raises `resp_valid_o` for exactly the following cycle. `resp_valid_o` is never high without a lookup on the previous edge.
- R4: On a miss response, `mem_req_valid_o` is high in the same cycle, `mem_req_addr_o` equals the looked-up address and `resp_data_o` is zero. On a hit response, `mem_req_valid_o` stays low.
- R5: On a hit with `displaced_valid_i` high, the displaced line takes over the hit entry. Afterwards the displaced address hits with its data and the requested address misses.
- R6: On a hit with `displaced_valid_i` low, the hit entry is emptied, so the requested address misses afterwards.
- R7: While any entry is empty, an eviction fills the lowest-numbered empty entry and overwrites no valid line.
- R8: When every entry is valid, an eviction overwrites the entry named by a replacement pointer. The pointer starts at entry 0 after reset, and advances by one with wrap-around only on such an overwrite.
- R9: An eviction presented in the same cycle as a lookup is ignored. Its address misses afterwards, and no stored line changes because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evict_valid_i | input | 1 | Line evicted by the cache is presented |
| evict_addr_i | input | ADDR_W | Full block address of the evicted line |
| evict_data_i | input | DATA_W | Data of the evicted line |
| lookup_valid_i | input | 1 | Lookup request after a cache miss |
| lookup_addr_i | input | ADDR_W | Full block address searched |
| displaced_valid_i | input | 1 | Cache holds a valid line that the requested block would replace |
| displaced_addr_i | input | ADDR_W | Block address of the displaced line |
| displaced_data_i | input | DATA_W | Data of the displaced line |
| resp_valid_o | output | 1 | Lookup answer valid |
| resp_hit_o | output | 1 | Requested block was in the buffer |
| resp_data_o | output | DATA_W | Block data on hit, zero on miss |
| mem_req_valid_o | output | 1 | Fetch request to next level |
| mem_req_addr_o | output | ADDR_W | Block address to fetch |

## Verification
Some rules are checked on every cycle by the assertions. These are the one-cycle response timing, the pairing of miss responses with memory requests and their address, and the rule that at most one entry matches. They also cover the choice of an empty slot before any overwrite, the replacement pointer holding still except on an overwrite, and the storage staying unchanged when a lookup and an eviction coincide. Other behaviour shows only through sequences that the bench drives. That includes data coming back after a swap, the order in which lines are overwritten once the buffer is full, and an emptied entry missing afterwards. The bench checks these against a reference model that it runs alongside the buffer.

// File: rtl/victim_buf_pkg.sv
package victim_buf_pkg;
  parameter int unsigned VB_LINES_DEF  = 8;
  parameter int unsigned VB_ADDR_W_DEF = 22;
  parameter int unsigned VB_DATA_W_DEF = 32;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int unsigned LINES  = 8,
  parameter int unsigned ADDR_W = 22
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [LINES-1:0]              valid_i,
  input  logic [LINES-1:0][ADDR_W-1:0]  tags_i,
  input  logic [ADDR_W-1:0]             addr_i,
  output logic                          hit_o,
  output logic [$clog2(LINES)-1:0]      idx_o
);
  localparam int unsigned IDX_W = $clog2(LINES);

  logic [LINES-1:0] hit_vec;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (tags_i[g] == addr_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hit_vec[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;

  // stored block addresses are unique, so at most one entry may match
  assert_single_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/vb_alloc.sv
module vb_alloc #(
  parameter int unsigned LINES = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LINES-1:0]          valid_i,
  input  logic                      ins_i,
  output logic [$clog2(LINES)-1:0]  idx_o
);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

  logic             full;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] ptr_q;

  assign full = &valid_i;

  always_comb begin
    free_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign idx_o = full ? ptr_q : free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ins_i && full) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assert_free_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_i && !full) |-> !valid_i[idx_o]);

  assert_ptr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ins_i && full) |=> $stable(ptr_q));
endmodule

// File: rtl/victim_buf.sv
module victim_buf
  import victim_buf_pkg::*;
#(
  parameter int unsigned LINES  = VB_LINES_DEF,
  parameter int unsigned ADDR_W = VB_ADDR_W_DEF,
  parameter int unsigned DATA_W = VB_DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic [DATA_W-1:0] evict_data_i,
  input  logic              lookup_valid_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  input  logic              displaced_valid_i,
  input  logic [ADDR_W-1:0] displaced_addr_i,
  input  logic [DATA_W-1:0] displaced_data_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              mem_req_valid_o,
  output logic [ADDR_W-1:0] mem_req_addr_o
);
  localparam int unsigned IDX_W = $clog2(LINES);

  logic [LINES-1:0]             valid_q;
  logic [LINES-1:0][ADDR_W-1:0] addr_q;
  logic [LINES-1:0][DATA_W-1:0] data_q;

  logic             m_hit;
  logic [IDX_W-1:0] m_idx;
  logic [IDX_W-1:0] a_idx;
  logic             ins;

  // a lookup owns the cycle; a coincident eviction is dropped
  assign ins = evict_valid_i && !lookup_valid_i;

  vb_match #(.LINES(LINES), .ADDR_W(ADDR_W)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_q),
    .tags_i  (addr_q),
    .addr_i  (lookup_addr_i),
    .hit_o   (m_hit),
    .idx_o   (m_idx)
  );

  vb_alloc #(.LINES(LINES)) u_alloc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_q),
    .ins_i   (ins),
    .idx_o   (a_idx)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_entry
    logic swap_here, ins_here;
    assign swap_here = lookup_valid_i && m_hit && (m_idx == IDX_W'(g));
    assign ins_here  = ins && (a_idx == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        addr_q[g]  <= '0;
        data_q[g]  <= '0;
      end else if (swap_here) begin
        valid_q[g] <= displaced_valid_i;
        if (displaced_valid_i) begin
          addr_q[g] <= displaced_addr_i;
          data_q[g] <= displaced_data_i;
        end
      end else if (ins_here) begin
        valid_q[g] <= 1'b1;
        addr_q[g]  <= evict_addr_i;
        data_q[g]  <= evict_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o    <= 1'b0;
      resp_hit_o      <= 1'b0;
      resp_data_o     <= '0;
      mem_req_valid_o <= 1'b0;
      mem_req_addr_o  <= '0;
    end else begin
      resp_valid_o    <= lookup_valid_i;
      resp_hit_o      <= lookup_valid_i && m_hit;
      resp_data_o     <= (lookup_valid_i && m_hit) ? data_q[m_idx] : '0;
      mem_req_valid_o <= lookup_valid_i && !m_hit;
      if (lookup_valid_i) mem_req_addr_o <= lookup_addr_i;
    end
  end

  assert_resp_next_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> resp_valid_o);

  assert_resp_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(lookup_valid_i));

  assert_req_on_miss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_hit_o) |-> mem_req_valid_o);

  assert_req_only_miss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (resp_valid_o && !resp_hit_o));

  assert_req_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_addr_o == $past(lookup_addr_i)));

  assert_evict_dropped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && evict_valid_i && !m_hit) |=> $stable(valid_q));
endmodule

// File: tb/victim_buf_tb.sv
`timescale 1ns/1ps
module victim_buf_tb;
  localparam int unsigned LINES  = 8;
  localparam int unsigned ADDR_W = 22;
  localparam int unsigned DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              evict_valid_i = 1'b0;
  logic [ADDR_W-1:0] evict_addr_i = '0;
  logic [DATA_W-1:0] evict_data_i = '0;
  logic              lookup_valid_i = 1'b0;
  logic [ADDR_W-1:0] lookup_addr_i = '0;
  logic              displaced_valid_i = 1'b0;
  logic [ADDR_W-1:0] displaced_addr_i = '0;
  logic [DATA_W-1:0] displaced_data_i = '0;
  logic              resp_valid_o, resp_hit_o, mem_req_valid_o;
  logic [DATA_W-1:0] resp_data_o;
  logic [ADDR_W-1:0] mem_req_addr_o;

  always #2 clk = ~clk;

  victim_buf #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .evict_valid_i(evict_valid_i), .evict_addr_i(evict_addr_i), .evict_data_i(evict_data_i),
    .lookup_valid_i(lookup_valid_i), .lookup_addr_i(lookup_addr_i),
    .displaced_valid_i(displaced_valid_i), .displaced_addr_i(displaced_addr_i),
    .displaced_data_i(displaced_data_i),
    .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o), .resp_data_o(resp_data_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o)
  );

  int unsigned n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  bit              m_v [LINES];
  bit [ADDR_W-1:0] m_a [LINES];
  bit [DATA_W-1:0] m_d [LINES];
  int unsigned     m_ptr = 0;
  int unsigned     fresh_ctr = 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] fresh();
    logic [ADDR_W-1:0] a;
    a = ADDR_W'(fresh_ctr * 32'd491);
    fresh_ctr++;
    return a;
  endfunction

  function automatic int find(input logic [ADDR_W-1:0] a);
    for (int i = 0; i < LINES; i++) if (m_v[i] && m_a[i] == a) return i;
    return -1;
  endfunction

  function automatic void model_insert(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    int slot = -1;
    for (int i = LINES - 1; i >= 0; i--) if (!m_v[i]) slot = i;
    if (slot < 0) begin
      slot = int'(m_ptr);
      m_ptr = (m_ptr + 1) % LINES;
    end
    m_v[slot] = 1'b1; m_a[slot] = a; m_d[slot] = d;
  endfunction

  task automatic do_evict(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    evict_valid_i = 1'b1; evict_addr_i = a; evict_data_i = d;
    @(negedge clk);
    evict_valid_i = 1'b0;
    model_insert(a, d);
  endtask

  task automatic do_lookup(input logic [ADDR_W-1:0] a, input bit dv,
                           input logic [ADDR_W-1:0] da, input logic [DATA_W-1:0] dd,
                           input bit ev, input logic [ADDR_W-1:0] ea,
                           input logic [DATA_W-1:0] ed, input string tag);
    int e;
    lookup_valid_i = 1'b1; lookup_addr_i = a;
    displaced_valid_i = dv; displaced_addr_i = da; displaced_data_i = dd;
    evict_valid_i = ev; evict_addr_i = ea; evict_data_i = ed;
    @(negedge clk);
    lookup_valid_i = 1'b0; displaced_valid_i = 1'b0; evict_valid_i = 1'b0;
    e = find(a);
    chk(resp_valid_o === 1'b1, {tag, " R3 resp_valid"}, 64'(resp_valid_o), 64'd1);
    chk(resp_hit_o === (e >= 0), {tag, " hit"}, 64'(resp_hit_o), 64'(e >= 0));
    if (e >= 0) begin
      chk(resp_data_o === m_d[e], {tag, " R2 data"}, 64'(resp_data_o), 64'(m_d[e]));
      chk(mem_req_valid_o === 1'b0, {tag, " R4 no req on hit"}, 64'(mem_req_valid_o), 64'd0);
      if (dv) begin m_a[e] = da; m_d[e] = dd; end
      else m_v[e] = 1'b0;
    end else begin
      chk(mem_req_valid_o === 1'b1 && mem_req_addr_o === a, {tag, " R4 mem req"},
          64'(mem_req_addr_o), 64'(a));
      chk(resp_data_o === '0, {tag, " R4 zero data"}, 64'(resp_data_o), 64'd0);
    end
  endtask

  task automatic look(input logic [ADDR_W-1:0] a, input string tag);
    do_lookup(a, 1'b0, '0, '0, 1'b0, '0, '0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] base [LINES];
    logic [ADDR_W-1:0] x, v, y;
    logic [DATA_W-1:0] vd;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < LINES; i++) m_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(resp_valid_o === 1'b0 && mem_req_valid_o === 1'b0, "R1 reset outputs",
        64'({resp_valid_o, mem_req_valid_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(resp_valid_o === 1'b0, "R3 no resp without lookup", 64'(resp_valid_o), 64'd0);
    look(fresh(), "R1 empty miss");

    // fill every entry, then overflow once
    for (int i = 0; i < LINES; i++) begin
      base[i] = fresh();
      do_evict(base[i], $urandom());
    end
    x = fresh();
    do_evict(x, $urandom());
    look(base[0], "R8 oldest overwritten");
    v = fresh(); vd = $urandom();
    do_lookup(base[1], 1'b1, v, vd, 1'b0, '0, '0, "R5 swap hit");
    look(base[1], "R5 requested gone");
    look(v, "R5 displaced present");
    look(v, "R6 emptied entry");
    look(base[2], "R7 kept while free");
    // R9: eviction coincident with a lookup is dropped
    y = fresh();
    do_lookup(x, 1'b1, fresh(), $urandom(), 1'b1, y, $urandom(), "R9 coincident");
    look(y, "R9 dropped evict");
    @(negedge clk);
    chk(resp_valid_o === 1'b0, "R3 single-cycle resp", 64'(resp_valid_o), 64'd0);

    // refill to full and check replacement order across wraps
    for (int i = 0; i < 3 * LINES; i++) do_evict(fresh(), $urandom());
    for (int i = 0; i < LINES; i++) begin
      if (m_v[i]) look(m_a[i], "R8 order after wrap");
    end

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned r = $urandom_range(0, 99);
      if (r < 40) begin
        do_evict(fresh(), $urandom());
      end else begin
        logic [ADDR_W-1:0] la;
        int pick = $urandom_range(0, LINES - 1);
        la = (r < 80 && m_v[pick]) ? m_a[pick] : fresh();
        if ($urandom_range(0, 9) < 7)
          do_lookup(la, 1'b1, fresh(), $urandom(), 1'b0, '0, '0, "R2 random");
        else
          do_lookup(la, 1'b0, '0, '0, 1'b0, '0, '0, "R6 random");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule